// File: doc/BRIEF.md
# Channel Clock Blocking Generator

This block drives two per-timeslot gating levels for a T1 line, one for the receive direction and one for the transmit direction. A serial or HDLC controller downstream uses each level to decide whether it should clock in data during the current timeslot. This lets a fractional T1 link carry payload in a chosen subset of the 24 channels. Each direction has its own bit-position counter. That counter advances on the direction's bit-enable strobe and realigns on its frame-sync input. Each direction also has a 24-bit channel map, held in three 8-bit registers.

A 193-bit frame starts with one framing bit and then carries 24 channels of 8 bits each. During a channel, the level equals that channel's map bit, and it holds for all 8 bit times. During the framing bit the level is low. Software writes the maps through a single-cycle write port. A new map value is sampled only when a channel begins, so the level never changes part-way through a channel.

All logic runs on one system clock. A bit time is marked by the direction's bit-enable strobe.

Top module: `chanBlockGen`

## Requirements
- R1: After reset all six map registers are 0, both bit positions are 0, and both `rxBlk` and `txBlk` are low.
- R2: Channel n (1 to 24) is controlled by bit (n-1)%8 of the register at base+(n-1)/8. In bit positions 1..192, position p belongs to channel ((p-1)/8)+1. While a channel's positions are current, the output equals the map bit sampled as that channel began.
- R3: Position 0 is the framing bit, and the output is low there. A bit-enable with sync moves the position to 0. A bit-enable without sync moves position 192 to 0 and any other position p to p+1.
- R4: The output changes only at a bit-enable edge that enters position 0 or the first bit of a channel (position 1, 9, ..., 185).
- R5: A map write takes effect from the first channel that begins at a later edge. A channel already in progress keeps its level.
- R6: The receive map is at addresses 0x6C, 0x6D and 0x6E, in channel order. The transmit map is at 0x6F, 0x70 and 0x71. The two directions are independent in registers, counters and outputs.
- R7: A write to any other address changes neither map.
- R8: Without a bit-enable, the bit position and the output hold and the sync input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| rxBitEn | input | 1 | Receive bit-time strobe |
| rxSync | input | 1 | Receive frame sync; qualified by rxBitEn |
| txBitEn | input | 1 | Transmit bit-time strobe |
| txSync | input | 1 | Transmit frame sync; qualified by txBitEn |
| rxBlk | output | 1 | Receive channel gating level |
| txBlk | output | 1 | Transmit channel gating level |

## Verification
The assertions check the following on every cycle:
- each level holds when its bit-enable is absent;
- each level never moves inside a channel;
- each level drops after a sync bit;
- both levels stay low through reset.

Some behaviour only the bench's scenarios can show. These are the address decode of each map register, the channel-to-bit mapping across the frame, the deferral of a map write to the next channel boundary, the independence of the two directions, and the rejection of writes to neighbouring addresses. The bench shows them by tracking bit positions and maps in its own model while phases, syncs and writes vary at random.

// File: rtl/chanBlkPkg.sv
package chanBlkPkg;
  localparam int CH_COUNT  = 24;
  localparam int CH_BITS   = 8;
  localparam int FRAME_LEN = CH_COUNT * CH_BITS + 1;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int IDX_W     = $clog2(CH_COUNT);
  localparam int REG_W     = 8;
  localparam int REG_N     = CH_COUNT / REG_W;
  localparam int DIR_N     = 2;

  // strobes from a slot counter to the datapath
  typedef struct packed {
    logic             tick;      // a bit edge happens this cycle
    logic             framing;   // that edge enters the framing bit
    logic             chanStart; // that edge enters a channel's first bit
    logic [IDX_W-1:0] chanIdx;   // zero-based channel entered
  } slotStrobe_t;
endpackage

// File: rtl/chanBlkCtrl.sv
module chanBlkCtrl
  import chanBlkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        sync,
  output slotStrobe_t st
);
  logic [POS_W-1:0] bitPos;
  logic [POS_W-1:0] nextPos;
  logic [POS_W-1:0] dataOff;

  always_comb begin
    if (sync) begin
      nextPos = '0;
    end else if (bitPos == POS_W'(FRAME_LEN - 1)) begin
      nextPos = '0;
    end else begin
      nextPos = bitPos + POS_W'(1);
    end
    dataOff = nextPos - POS_W'(1);
  end

  always_comb begin
    st.tick      = bitEn;
    st.framing   = (nextPos == '0);
    st.chanStart = (nextPos != '0) && ((dataOff % POS_W'(CH_BITS)) == '0);
    st.chanIdx   = IDX_W'(dataOff / POS_W'(CH_BITS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= '0;
    end else if (bitEn) begin
      bitPos <= nextPos;
    end
  end
endmodule

// File: rtl/chanBlkData.sv
module chanBlkData
  import chanBlkPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int RX_BASE = 'h6C,
  parameter int TX_BASE = 'h6F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  slotStrobe_t       rxSt,
  input  slotStrobe_t       txSt,
  output logic              rxBlk,
  output logic              txBlk
);
  logic [CH_COUNT-1:0] chanMap [DIR_N];
  slotStrobe_t         dirSt   [DIR_N];
  logic                blkQ    [DIR_N];

  assign dirSt[0] = rxSt;
  assign dirSt[1] = txSt;

  for (genvar d = 0; d < DIR_N; d++) begin : g_dir
    localparam int BASE = (d == 0) ? RX_BASE : TX_BASE;

    for (genvar g = 0; g < REG_N; g++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chanMap[d][g*REG_W +: REG_W] <= '0;
        end else if (wrEn && (wrAddr == ADDR_W'(BASE + g))) begin
          chanMap[d][g*REG_W +: REG_W] <= wrData;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        blkQ[d] <= 1'b0;
      end else if (dirSt[d].tick) begin
        if (dirSt[d].framing) begin
          blkQ[d] <= 1'b0;
        end else if (dirSt[d].chanStart) begin
          blkQ[d] <= chanMap[d][dirSt[d].chanIdx];
        end
      end
    end
  end

  assign rxBlk = blkQ[0];
  assign txBlk = blkQ[1];
endmodule

// File: rtl/chanBlockGen.sv
module chanBlockGen
  import chanBlkPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int RX_BASE = 'h6C,
  parameter int TX_BASE = 'h6F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rxBitEn,
  input  logic              rxSync,
  input  logic              txBitEn,
  input  logic              txSync,
  output logic              rxBlk,
  output logic              txBlk
);
  slotStrobe_t rxSt;
  slotStrobe_t txSt;

  chanBlkCtrl u_rxCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .bitEn (rxBitEn),
    .sync  (rxSync),
    .st    (rxSt)
  );

  chanBlkCtrl u_txCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .bitEn (txBitEn),
    .sync  (txSync),
    .st    (txSt)
  );

  chanBlkData #(
    .ADDR_W  (ADDR_W),
    .RX_BASE (RX_BASE),
    .TX_BASE (TX_BASE)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rxSt   (rxSt),
    .txSt   (txSt),
    .rxBlk  (rxBlk),
    .txBlk  (txBlk)
  );
endmodule

// File: rtl/chanBlkChk.sv
module chanBlkChk
  import chanBlkPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        rxBitEn,
  input logic        rxSync,
  input logic        txBitEn,
  input logic        txSync,
  input logic        rxBlk,
  input logic        txBlk,
  input slotStrobe_t rxSt,
  input slotStrobe_t txSt
);
  p_reset_low_r1: assert property (@(posedge clk)
    !rstN |=> (!rxBlk && !txBlk));

  p_rx_frame_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxBitEn && rxSync) |=> !rxBlk);

  p_tx_frame_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txBitEn && txSync) |=> !txBlk);

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rxBitEn |=> $stable(rxBlk));

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !txBitEn |=> $stable(txBlk));

  p_rx_no_glitch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxBitEn && !rxSt.framing && !rxSt.chanStart) |=> $stable(rxBlk));

  p_tx_no_glitch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txBitEn && !txSt.framing && !txSt.chanStart) |=> $stable(txBlk));
endmodule

bind chanBlockGen chanBlkChk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rxBitEn (rxBitEn),
  .rxSync  (rxSync),
  .txBitEn (txBitEn),
  .txSync  (txSync),
  .rxBlk   (rxBlk),
  .txBlk   (txBlk),
  .rxSt    (rxSt),
  .txSt    (txSt)
);

// File: tb/sim_chanBlockGen.sv
module sim_chanBlockGen;
  localparam int CLK_PERIOD = 10;
  localparam int LAST_POS   = 192;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [7:0] wrAddr;
  logic [7:0] wrData;
  logic       rxBitEn, rxSync, txBitEn, txSync;
  logic       rxBlk, txBlk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int        posM   [2];
  bit        outM   [2];
  bit        lastEn [2];
  bit [23:0] mapM   [2];
  string     curTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  chanBlockGen u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rxBitEn(rxBitEn), .rxSync(rxSync), .txBitEn(txBitEn), .txSync(txSync),
    .rxBlk(rxBlk), .txBlk(txBlk)
  );

  function automatic int nextPosOf(int p, bit sy);
    if (sy) return 0;
    if (p == LAST_POS) return 0;
    return p + 1;
  endfunction

  task automatic modelEdge(int d, bit en, bit sy);
    int np;
    lastEn[d] = en;
    if (!en) return;
    np = nextPosOf(posM[d], sy);
    if (np == 0) outM[d] = 1'b0;
    else if (((np - 1) % 8) == 0) outM[d] = mapM[d][(np - 1) / 8];
    posM[d] = np;
  endtask

  task automatic modelWrite(bit we, logic [7:0] a, logic [7:0] v);
    if (!we) return;
    for (int i = 0; i < 3; i++) begin
      if (a == 8'(8'h6C + i)) mapM[0][i*8 +: 8] = v;
      if (a == 8'(8'h6F + i)) mapM[1][i*8 +: 8] = v;
    end
  endtask

  task automatic checkOne(string name, int d, logic act);
    string tag;
    if (posM[d] == 0) tag = "R3";
    else if (!lastEn[d]) tag = "R8";
    else tag = curTag;
    checks++;
    if (act !== outM[d]) begin
      errors++;
      $display("FAIL %s %s pos=%0d actual=%b expected=%b", tag, name, posM[d], act, outM[d]);
    end
  endtask

  // called at a negedge: check the last edge, then drive the next one
  task automatic cycle(bit rE, bit rS, bit tE, bit tS, bit we, logic [7:0] a, logic [7:0] v);
    checkOne("rxBlk", 0, rxBlk);
    checkOne("txBlk", 1, txBlk);
    rxBitEn = rE; rxSync = rS; txBitEn = tE; txSync = tS;
    wrEn = we; wrAddr = a; wrData = v;
    modelEdge(0, rE, rS);
    modelEdge(1, tE, tS);
    modelWrite(we, a, v);
    @(negedge clk);
  endtask

  task automatic bits(bit rOn, bit tOn, int n);
    for (int i = 0; i < n; i++)
      cycle(rOn, rOn && posM[0] == LAST_POS, tOn, tOn && posM[1] == LAST_POS, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic regWrite(logic [7:0] a, logic [7:0] v);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, a, v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4217));
    rstN = 1'b0; wrEn = 0; wrAddr = 0; wrData = 0;
    rxBitEn = 0; rxSync = 0; txBitEn = 0; txSync = 0;
    for (int d = 0; d < 2; d++) begin
      posM[d] = 0; outM[d] = 0; lastEn[d] = 0; mapM[d] = '0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, outputs low across a full frame with empty maps
    curTag = "R1";
    bits(1, 1, 200);

    // R5: write in the middle of channel 1 waits for channel 2
    curTag = "R5";
    cycle(1, 1, 0, 0, 0, 8'h00, 8'h00);
    bits(1, 0, 4);
    regWrite(8'h6C, 8'hFF);
    bits(1, 0, 8);
    regWrite(8'h6C, 8'h00);
    bits(1, 0, 12);

    // R6: transmit map only; receive stays low
    curTag = "R6";
    regWrite(8'h6F, 8'hA5);
    regWrite(8'h70, 8'h3C);
    regWrite(8'h71, 8'h81);
    bits(1, 1, 400);
    regWrite(8'h6F, 8'h00);
    regWrite(8'h70, 8'h00);
    regWrite(8'h71, 8'h00);

    // R7: neighbouring addresses must not reach either map
    curTag = "R7";
    regWrite(8'h6B, 8'hFF);
    regWrite(8'h72, 8'hFF);
    regWrite(8'hEC, 8'hFF);
    bits(1, 1, 400);

    // R2: every channel lit on receive, checkerboard on transmit
    curTag = "R2";
    for (int i = 0; i < 3; i++) regWrite(8'(8'h6C + i), 8'hFF);
    for (int i = 0; i < 3; i++) regWrite(8'(8'h6F + i), 8'h55);
    bits(1, 1, 400);

    // random phase: gaps, independent syncs, stray syncs, random writes
    for (int c = 0; c < 30000; c++) begin
      bit rE, tE, rS, tS, we;
      logic [7:0] a, v;
      rE = ($urandom % 3) != 0;
      tE = ($urandom % 3) != 0;
      rS = (posM[0] == LAST_POS) ? (($urandom % 10) != 0) : (($urandom % 500) == 0);
      tS = (posM[1] == LAST_POS) ? (($urandom % 10) != 0) : (($urandom % 500) == 0);
      we = ($urandom % 40) == 0;
      a  = 8'(8'h6A + ($urandom % 10));
      case ($urandom % 4)
        0: v = 8'hFF;
        1: v = 8'h00;
        default: v = 8'($urandom);
      endcase
      cycle(rE, rS, tE, tS, we, a, v);
    end
    checkOne("rxBlk", 0, rxBlk);
    checkOne("txBlk", 1, txBlk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule